// File: doc/BRIEF.md
# Memory-Mapped Character FIFO Port

This block connects an embedded processor to an external byte-stream peer, one 8-bit character at a time. The processor sees two 32-bit words on a simple word-addressed slave: a data word and a control word. Writing the data word queues a character for the peer; reading it takes the oldest character received from the peer, together with a flag saying whether that character is real and a count of what is still waiting.

Behind the data word sit two FIFOs, one per direction, each 8 bits wide and of parameter depth. The peer side is a pair of valid/ready byte streams. A single active-high interrupt line combines a receive-side condition (the receive FIFO is close to full) and a transmit-side condition (the transmit FIFO is close to empty), each with its own enable bit and threshold.

Software typically polls the data word until the valid flag is set, or enables the interrupts and drains or refills a FIFO in the handler.

Top module: `char_port`

## Requirements
- R1: After reset both FIFOs are empty, both interrupt enables are clear, `irq` and `out_valid` are low and `in_ready` is high.
- R2: A bus write with `bus_addr`=0 queues `bus_wdata[7:0]` (upper bits ignored) in the transmit FIFO; `out_data` presents the oldest queued character while `out_valid` is high, and one character leaves on every cycle where `out_valid` and `out_ready` are both high, in write order.
- R3: A bus read with `bus_addr`=0 on a non-empty receive FIFO removes the oldest character and, on `bus_rdata` from the next cycle on, returns it in bits 7:0, bit 15 set, bits 14:8 zero and bits 31:16 equal to the number of characters held before the read minus one.
- R4: A data read on an empty receive FIFO returns bit 15 clear (and zero elsewhere) and leaves the receive FIFO contents unchanged.
- R5: A data write while the transmit FIFO is full at that cycle is dropped; the queued characters are unchanged.
- R6: `in_ready` is low whenever the receive FIFO is full; a character is stored only on a cycle where `in_valid` and `in_ready` are both high.
- R7: The control word (`bus_addr`=1) reads the read-interrupt enable at bit 0, the write-interrupt enable at bit 1, the raw read condition at bit 8, the raw write condition at bit 9 and the transmit FIFO free space at bits 31:16; a control write loads bits 0 and 1 only.
- R8: The read condition is true when the receive FIFO free space is less than or equal to `RD_THRESH`.
- R9: The write condition is true when the transmit FIFO holds `WR_THRESH` characters or fewer.
- R10: `irq` is high exactly when an enabled condition is true; with both enables clear it stays low.
- R11: A data read and a peer character arriving in the same cycle both take effect: the read returns the oldest character and the new one is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Word select: 0 data, 1 control |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd` |
| irq | output | 1 | Active-high interrupt request |
| in_valid | input | 1 | Peer offers a character |
| in_ready | output | 1 | Receive FIFO can accept |
| in_data | input | 8 | Character from the peer |
| out_valid | output | 1 | Transmit FIFO has a character |
| out_ready | input | 1 | Peer accepts a character |
| out_data | output | 8 | Character to the peer |

## Verification
The receive FIFO can be popped by a data read and pushed by the peer in the same cycle, and the transmit FIFO can be pushed by the bus and drained by the peer in the same cycle. The bench provokes the receive case by raising `bus_rd` and `in_valid` at one clock edge with two characters already queued, then judges the returned word's count field and the order of the two following reads. A checker asserts that the receive count is stable across such a cycle and that a full transmit FIFO never grows.

// File: rtl/cport_pkg.sv
package cport_pkg;
   localparam logic ADDR_DATA = 1'b0;
   localparam logic ADDR_CTRL = 1'b1;

   localparam int CTRL_RE_BIT  = 0;
   localparam int CTRL_WE_BIT  = 1;
   localparam int CTRL_RI_BIT  = 8;
   localparam int CTRL_WI_BIT  = 9;
   localparam int DATA_VLD_BIT = 15;
   localparam int FIELD_LSB    = 16;

   localparam int CHAR_W  = 8;
   localparam int WORD_W  = 32;
   localparam int FIELD_W = 16;

   localparam int DEPTH_MIN = 8;
   localparam int DEPTH_MAX = 32768;

   typedef struct packed {
      logic rd_en;
      logic wr_en;
   } irq_en_t;

   function automatic logic [WORD_W-1:0] data_word(input logic vld,
                                                   input logic [CHAR_W-1:0] ch,
                                                   input logic [FIELD_W-1:0] left);
      logic [WORD_W-1:0] w;
      w = '0;
      w[FIELD_LSB +: FIELD_W] = left;
      w[DATA_VLD_BIT]         = vld;
      w[CHAR_W-1:0]           = vld ? ch : '0;
      return w;
   endfunction

   function automatic logic [WORD_W-1:0] ctrl_word(input irq_en_t en,
                                                   input logic ri, input logic wi,
                                                   input logic [FIELD_W-1:0] free);
      logic [WORD_W-1:0] w;
      w = '0;
      w[FIELD_LSB +: FIELD_W] = free;
      w[CTRL_WI_BIT]          = wi;
      w[CTRL_RI_BIT]          = ri;
      w[CTRL_WE_BIT]          = en.wr_en;
      w[CTRL_RE_BIT]          = en.rd_en;
      return w;
   endfunction
endpackage

// File: rtl/cport_fifo.sv
module cport_fifo #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 8,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);
   localparam bit POW2 = (DEPTH == (1 << AW));

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr, wptr_nx, rptr_nx;
   logic             do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rptr];

   // pointer advance: free wrap on a power-of-two depth, compare otherwise
   generate
      if (POW2) begin : g_wrap_free
         assign wptr_nx = wptr + 1'b1;
         assign rptr_nx = rptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/cport_irq.sv
module cport_irq
   import cport_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter int RD_THRESH = 8,
   parameter int WR_THRESH = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  irq_en_t       en,
   input  logic [CW-1:0] rx_count,
   input  logic [CW-1:0] tx_count,
   output logic [CW-1:0] rx_free,
   output logic [CW-1:0] tx_free,
   output logic          rd_cond,
   output logic          wr_cond,
   output logic          irq
);
   assign rx_free = CW'(DEPTH) - rx_count;
   assign tx_free = CW'(DEPTH) - tx_count;
   assign rd_cond = (rx_free <= CW'(RD_THRESH));
   assign wr_cond = (tx_count <= CW'(WR_THRESH));
   assign irq     = (en.rd_en && rd_cond) || (en.wr_en && wr_cond);
endmodule

// File: rtl/cport_regs.sv
module cport_regs
   import cport_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic [CHAR_W-1:0] rx_head,
   input  logic [CW-1:0]     rx_count,
   input  logic [CW-1:0]     tx_free,
   input  logic              rd_cond,
   input  logic              wr_cond,
   output logic              rx_pop,
   output logic              tx_push,
   output logic [CHAR_W-1:0] tx_char,
   output irq_en_t           en
);
   logic          rx_has;
   logic [CW-1:0] rx_left;

   assign rx_has  = (rx_count != '0);
   assign rx_left = rx_count - CW'(rx_has);
   assign rx_pop  = bus_rd && (bus_addr == ADDR_DATA);
   assign tx_push = bus_wr && (bus_addr == ADDR_DATA);
   assign tx_char = bus_wdata[CHAR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= '0;
      end else if (bus_wr && (bus_addr == ADDR_CTRL)) begin
         en.rd_en <= bus_wdata[CTRL_RE_BIT];
         en.wr_en <= bus_wdata[CTRL_WE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         if (bus_addr == ADDR_DATA)
            bus_rdata <= data_word(rx_has, rx_head, FIELD_W'(rx_left));
         else
            bus_rdata <= ctrl_word(en, rd_cond, wr_cond, FIELD_W'(tx_free));
      end
   end
endmodule

// File: rtl/char_port.sv
module char_port
   import cport_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter int RD_THRESH = 8,
   parameter int WR_THRESH = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_addr,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq,
   input  logic        in_valid,
   output logic        in_ready,
   input  logic [7:0]  in_data,
   output logic        out_valid,
   input  logic        out_ready,
   output logic [7:0]  out_data
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < DEPTH_MIN || DEPTH > DEPTH_MAX) begin : g_bad_depth
         $error("char_port: DEPTH out of range");
      end
      if (RD_THRESH < 0 || RD_THRESH >= DEPTH) begin : g_bad_rd
         $error("char_port: RD_THRESH must be below DEPTH");
      end
      if (WR_THRESH < 0 || WR_THRESH >= DEPTH) begin : g_bad_wr
         $error("char_port: WR_THRESH must be below DEPTH");
      end
   endgenerate

   logic [CW-1:0]     rx_cnt, tx_cnt, rx_free, tx_free;
   logic [CHAR_W-1:0] rx_head, tx_char;
   logic              rx_full, rx_empty, tx_full, tx_empty;
   logic              rx_pop, tx_push, rd_cond, wr_cond;
   irq_en_t           en;
   logic              ie_rd, ie_wr;

   assign ie_rd     = en.rd_en;
   assign ie_wr     = en.wr_en;
   assign in_ready  = !rx_full;
   assign out_valid = !tx_empty;

   cport_fifo #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .push(in_valid), .push_data(in_data),
      .pop(rx_pop), .head(rx_head),
      .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   cport_fifo #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .push_data(tx_char),
      .pop(out_ready), .head(out_data),
      .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   cport_regs #(.DEPTH(DEPTH)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_head(rx_head), .rx_count(rx_cnt), .tx_free(tx_free),
      .rd_cond(rd_cond), .wr_cond(wr_cond),
      .rx_pop(rx_pop), .tx_push(tx_push), .tx_char(tx_char), .en(en)
   );

   cport_irq #(.DEPTH(DEPTH), .RD_THRESH(RD_THRESH), .WR_THRESH(WR_THRESH)) u_irq (
      .en(en), .rx_count(rx_cnt), .tx_count(tx_cnt),
      .rx_free(rx_free), .tx_free(tx_free),
      .rd_cond(rd_cond), .wr_cond(wr_cond), .irq(irq)
   );
endmodule

// File: rtl/cport_chk.sv
module cport_chk #(
   parameter int DEPTH = 64,
   parameter int CW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_addr,
   input logic          bus_wr,
   input logic          bus_rd,
   input logic [31:0]   bus_rdata,
   input logic          irq,
   input logic          in_valid,
   input logic          in_ready,
   input logic          out_valid,
   input logic          out_ready,
   input logic [CW-1:0] rx_cnt,
   input logic [CW-1:0] tx_cnt,
   input logic          ie_rd,
   input logic          ie_wr
);
   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

   assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_addr && rx_cnt == '0) |=> !bus_rdata[15]);

   assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_addr && rx_cnt == '0 && !in_valid) |=> (rx_cnt == '0));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt == CW'(DEPTH) && bus_wr && !bus_addr && !(out_valid && out_ready))
      |=> (tx_cnt == CW'(DEPTH)));

   assert_rx_full_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == CW'(DEPTH)) |-> !in_ready);

   assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_rd && !ie_wr) |-> !irq);

   assert_same_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_addr && rx_cnt != '0 && in_valid && in_ready) |=> $stable(rx_cnt));
endmodule

bind char_port cport_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
   .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready),
   .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .ie_rd(ie_rd), .ie_wr(ie_wr)
);

// File: tb/char_port_tb.sv
module char_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, in_ready, out_valid;
   logic        in_valid = 1'b0, out_ready = 1'b0;
   logic [7:0]  in_data = '0;
   logic [7:0]  out_data;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   char_port #(.DEPTH(8), .RD_THRESH(2), .WR_THRESH(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic bus_write(input logic a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic peer_give(input logic [7:0] b);
      in_data = b; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic peer_take(output logic [7:0] b);
      b = out_data; out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 in_ready", {31'b0, in_ready}, 32'd1);
      check("R1 out_valid", {31'b0, out_valid}, 32'd0);
      check("R1 irq", {31'b0, irq}, 32'd0);
      bus_read(1'b1, d);
      check("R1 R7 ctrl after reset", d, 32'h0008_0200);
      bus_read(1'b0, d);
      check("R4 empty read after reset", d, 32'h0000_0000);
   endtask

   task automatic t_tx_order();
      logic [31:0] d;
      logic [7:0] b;
      bus_write(1'b0, 32'hABCD_EF41);
      bus_write(1'b0, 32'h0000_0042);
      bus_write(1'b0, 32'hFFFF_FF43);
      check("R2 out_valid", {31'b0, out_valid}, 32'd1);
      bus_read(1'b1, d);
      check("R7 ctrl free=5 WI", d, 32'h0005_0200);
      for (int i = 0; i < 3; i++) begin
         peer_take(b);
         check("R2 tx order", {24'b0, b}, 32'h41 + i);
      end
      check("R2 out_valid drained", {31'b0, out_valid}, 32'd0);
   endtask

   task automatic t_tx_full();
      logic [31:0] d;
      logic [7:0] b;
      for (int i = 0; i < 10; i++) bus_write(1'b0, 32'h50 + i);
      bus_read(1'b1, d);
      check("R5 R7 free zero when full", {16'b0, d[31:16]}, 32'd0);
      for (int i = 0; i < 8; i++) begin
         peer_take(b);
         check("R5 kept chars", {24'b0, b}, 32'h50 + i);
      end
      check("R5 overflow dropped", {31'b0, out_valid}, 32'd0);
   endtask

   task automatic t_rx();
      logic [31:0] d;
      peer_give(8'h11); peer_give(8'h22); peer_give(8'h33);
      bus_read(1'b0, d); check("R3 read 1", d, 32'h0002_8011);
      bus_read(1'b0, d); check("R3 read 2", d, 32'h0001_8022);
      bus_read(1'b0, d); check("R3 read 3", d, 32'h0000_8033);
      bus_read(1'b0, d); check("R4 empty read", d, 32'h0000_0000);
      peer_give(8'h44);
      bus_read(1'b0, d); check("R4 no pointer move", d, 32'h0000_8044);
   endtask

   task automatic t_rx_full();
      logic [31:0] d;
      for (int i = 0; i < 8; i++) peer_give(8'h60 + 8'(i));
      check("R6 in_ready low when full", {31'b0, in_ready}, 32'd0);
      peer_give(8'h99);
      for (int i = 0; i < 8; i++) begin
         bus_read(1'b0, d);
         check("R6 rx contents", d, {16'(7 - i), 16'h8060 + 16'(i)});
      end
      bus_read(1'b0, d); check("R6 extra byte not stored", {31'b0, d[15]}, 32'd0);
      check("R6 in_ready back", {31'b0, in_ready}, 32'd1);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      logic [7:0] b;
      bus_write(1'b1, 32'hFFFF_FC01);
      check("R8 R10 no read irq when empty", {31'b0, irq}, 32'd0);
      for (int i = 0; i < 6; i++) peer_give(8'(i));
      check("R8 read irq at free=2", {31'b0, irq}, 32'd1);
      bus_read(1'b1, d);
      check("R7 ctrl with RE RI WI", d, 32'h0008_0301);
      bus_read(1'b0, d);
      check("R8 read irq clears at free=3", {31'b0, irq}, 32'd0);
      for (int i = 0; i < 5; i++) bus_read(1'b0, d);
      bus_write(1'b1, 32'h0000_0002);
      check("R9 write irq when tx empty", {31'b0, irq}, 32'd1);
      for (int i = 0; i < 4; i++) bus_write(1'b0, 32'h70 + i);
      check("R9 write irq off at count 4", {31'b0, irq}, 32'd0);
      peer_take(b);
      check("R9 write irq on at count 3", {31'b0, irq}, 32'd1);
      for (int i = 0; i < 3; i++) peer_take(b);
      bus_write(1'b1, 32'h0000_0000);
      check("R10 irq low with enables clear", {31'b0, irq}, 32'd0);
      bus_read(1'b1, d);
      check("R7 WI raw while disabled", d, 32'h0008_0200);
   endtask

   task automatic t_same_cycle();
      logic [31:0] d;
      peer_give(8'h21); peer_give(8'h22);
      bus_addr = 1'b0; bus_rd = 1'b1; in_data = 8'h77; in_valid = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0; in_valid = 1'b0;
      check("R11 read during push", bus_rdata, 32'h0001_8021);
      bus_read(1'b0, d); check("R11 second char", d, 32'h0001_8022);
      bus_read(1'b0, d); check("R11 pushed char kept", d, 32'h0000_8077);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tx_order();
      t_tx_full();
      t_rx();
      t_rx_full();
      t_irq();
      t_same_cycle();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule